// File: doc/BRIEF.md
# Packed-Instruction Fetch Sequencer

This block fetches instructions for a one-address machine whose 40-bit memory words each carry two 20-bit instructions. It holds a 12-bit word program counter together with a one-bit half-select flag. It reads one word at a time through a synchronous memory read port and buffers that word. It then presents one 20-bit half of the word to the decode stage, with the PC and half-select that locate it.

The execution unit raises a done strobe when it has finished the instruction on offer. The sequencer then works out where execution continues. The low half of a word runs before its high half, so after the low half it moves to the high half of the buffered word without another read. After the high half it moves on to the next word. Four branch opcodes can redirect the flow to either half of any word. Two of them always branch. The other two branch only when the accumulator sign bit from the datapath is clear. Any branch that is taken causes a fresh memory read. Because the sequencer waits for the done strobe, operations that take many cycles hold the fetch in place.

Top module: `pkd_fetch_seq`

## Requirements
- R1: While reset (active-low, synchronous) is held, the PC and half-select read 0, a read of address 0 is requested, and no instruction is offered. The first word fetched after reset is word 0.
- R2: A read request lasts one cycle with the address equal to the PC. The instruction taken from the returned word is offered two cycles after the request, and no read is requested while an instruction is offered.
- R3: With half-select 0 the offered instruction is bits [19:0] of the word. With half-select 1 it is bits [39:20].
- R4: After done on a half-0 instruction that does not branch, the next offer is half 1 of the same word, with the same PC and no new read.
- R5: After done on a half-1 instruction that does not branch, the PC increments modulo 4096, half-select becomes 0 and a new read is made. Word 4095 is followed by word 0.
- R6: The instruction layout is opcode in bits [19:12] and target address in bits [11:0]. Opcode 0x08 always loads the PC from the target with half-select 0. Opcode 0x09 does the same with half-select 1.
- R7: Opcodes 0x0A and 0x0B act as 0x08 and 0x09 when the accumulator sign input is 0 at done. When it is 1 they step on as in R4/R5. The sign input does not affect 0x08/0x09.
- R8: An offered instruction, with its PC and half-select, stays unchanged until done. A done strobe while nothing is offered is ignored.
- R9: A taken branch always refetches, even when its target is the word already buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rd_en | output | 1 | Read request to the synchronous memory |
| mem_rd_addr | output | 12 | Word address of the read |
| mem_rd_data | input | 40 | Word returned one cycle after the request |
| dec_valid | output | 1 | An instruction is offered to decode |
| dec_instr | output | 20 | Offered instruction |
| dec_pc | output | 12 | Word address of the offered instruction |
| dec_half | output | 1 | Half-select of the offered instruction |
| exe_done | input | 1 | Execution of the offered instruction has finished |
| acc_sign | input | 1 | Accumulator sign bit, sampled with exe_done |

## Verification
The assertions watch the port-level rules on every cycle. These rules are: no read while an instruction is offered, the two-cycle gap from request to offer, the hold of an offer until done, the move to the high half without a read, and the read address that follows a high-half instruction or a branch. Only the bench scenarios can show the things that depend on memory contents and sequences. These are the correct half being extracted, the exact chain of PCs through branches of every kind, the refetch of a word that is already buffered, the wrap from word 4095 to 0, and the reset values.

// File: rtl/pkd_fetch_pkg.sv
package pkd_fetch_pkg;

    localparam int unsigned OPC_W = 8;

    // Branch opcodes: bit 1 marks the conditional form, bit 0 picks the half.
    localparam logic [OPC_W-1:0] OP_JMP_LO = 8'h08;
    localparam logic [OPC_W-1:0] OP_JMP_HI = 8'h09;
    localparam logic [OPC_W-1:0] OP_JGE_LO = 8'h0A;
    localparam logic [OPC_W-1:0] OP_JGE_HI = 8'h0B;

    typedef enum logic [1:0] {
        ST_REQ     = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_PRESENT = 2'd2
    } fetch_st_e;

endpackage

// File: rtl/pkd_branch_eval.sv
module pkd_branch_eval
    import pkd_fetch_pkg::*;
#(
    parameter int unsigned AW = 12,
    parameter int unsigned IW = 20
) (
    input  logic [IW-1:0] instr,
    input  logic          acc_sign,
    output logic          is_branch,
    output logic          taken,
    output logic          tgt_half,
    output logic [AW-1:0] tgt_addr
);
    logic [OPC_W-1:0] opcode;
    logic             is_cond;

    always_comb begin
        opcode    = instr[IW-1 -: OPC_W];
        is_branch = (opcode == OP_JMP_LO) || (opcode == OP_JMP_HI) ||
                    (opcode == OP_JGE_LO) || (opcode == OP_JGE_HI);
        is_cond   = opcode[1];
        tgt_half  = opcode[0];
        tgt_addr  = instr[AW-1:0];
        taken     = is_branch && (!is_cond || !acc_sign);
    end
endmodule

// File: rtl/pkd_seq_step.sv
module pkd_seq_step #(
    parameter int unsigned AW = 12
) (
    input  logic [AW-1:0] pc,
    input  logic          half,
    input  logic          taken,
    input  logic          tgt_half,
    input  logic [AW-1:0] tgt_addr,
    output logic [AW-1:0] nxt_pc,
    output logic          nxt_half,
    output logic          need_fetch
);
    always_comb begin
        if (taken) begin
            nxt_pc     = tgt_addr;
            nxt_half   = tgt_half;
            need_fetch = 1'b1;
        end else if (half) begin
            nxt_pc     = pc + AW'(1);
            nxt_half   = 1'b0;
            need_fetch = 1'b1;
        end else begin
            nxt_pc     = pc;
            nxt_half   = 1'b1;
            need_fetch = 1'b0;
        end
    end
endmodule

// File: rtl/pkd_half_mux.sv
module pkd_half_mux #(
    parameter int unsigned IW     = 20,
    parameter int unsigned SLOTS  = 2,
    localparam int unsigned SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS*IW-1:0] word,
    input  logic [SEL_W-1:0]    sel,
    output logic [IW-1:0]       instr
);
    logic [IW-1:0] slot [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot[g] = word[g*IW +: IW];
    end

    always_comb begin
        instr = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (SEL_W'(i) == sel) instr = slot[i];
        end
    end
endmodule

// File: rtl/pkd_fetch_seq.sv
module pkd_fetch_seq
    import pkd_fetch_pkg::*;
#(
    parameter int unsigned AW = 12,
    parameter int unsigned IW = 20,
    localparam int unsigned WW = 2 * IW
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [WW-1:0] mem_rd_data,
    output logic          dec_valid,
    output logic [IW-1:0] dec_instr,
    output logic [AW-1:0] dec_pc,
    output logic          dec_half,
    input  logic          exe_done,
    input  logic          acc_sign
);
    typedef struct packed {
        fetch_st_e     state;
        logic [AW-1:0] pc;
        logic          half;
        logic [WW-1:0] word;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          br_is, br_taken, br_half;
    logic [AW-1:0] br_addr;
    logic [AW-1:0] step_pc;
    logic          step_half, step_fetch;
    logic [IW-1:0] cur_instr;

    pkd_half_mux #(.IW(IW), .SLOTS(2)) u_mux (
        .word  (seq_q.word),
        .sel   (seq_q.half),
        .instr (cur_instr)
    );

    pkd_branch_eval #(.AW(AW), .IW(IW)) u_br (
        .instr     (cur_instr),
        .acc_sign  (acc_sign),
        .is_branch (br_is),
        .taken     (br_taken),
        .tgt_half  (br_half),
        .tgt_addr  (br_addr)
    );

    pkd_seq_step #(.AW(AW)) u_step (
        .pc         (seq_q.pc),
        .half       (seq_q.half),
        .taken      (br_taken),
        .tgt_half   (br_half),
        .tgt_addr   (br_addr),
        .nxt_pc     (step_pc),
        .nxt_half   (step_half),
        .need_fetch (step_fetch)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_REQ: begin
                seq_d.state = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                seq_d.word  = mem_rd_data;
                seq_d.state = ST_PRESENT;
            end
            ST_PRESENT: begin
                if (exe_done) begin
                    seq_d.pc    = step_pc;
                    seq_d.half  = step_half;
                    seq_d.state = step_fetch ? ST_REQ : ST_PRESENT;
                end
            end
            default: begin
                seq_d.state = ST_REQ;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_REQ, pc: '0, half: 1'b0, word: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_rd_en   = (seq_q.state == ST_REQ);
    assign mem_rd_addr = seq_q.pc;
    assign dec_valid   = (seq_q.state == ST_PRESENT);
    assign dec_instr   = cur_instr;
    assign dec_pc      = seq_q.pc;
    assign dec_half    = seq_q.half;

    logic unused_br_is;
    assign unused_br_is = br_is;
endmodule

// File: rtl/pkd_fetch_seq_chk.sv
module pkd_fetch_seq_chk #(
    parameter int unsigned AW = 12,
    parameter int unsigned IW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic          dec_valid,
    input logic [IW-1:0] dec_instr,
    input logic [AW-1:0] dec_pc,
    input logic          dec_half,
    input logic          exe_done,
    input logic          acc_sign
);
    logic [7:0] opc;
    logic       op_jmp, op_jge, steps_on;
    assign opc      = dec_instr[IW-1 -: 8];
    assign op_jmp   = (opc == 8'h08) || (opc == 8'h09);
    assign op_jge   = (opc == 8'h0A) || (opc == 8'h0B);
    assign steps_on = !op_jmp && !(op_jge && !acc_sign);

    p_no_read_offer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !dec_valid);

    p_req_to_offer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (!dec_valid && !mem_rd_en) ##1 dec_valid);

    p_hold_offer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !exe_done) |=>
            (dec_valid && $stable(dec_instr) && $stable(dec_pc) && $stable(dec_half)));

    p_low_to_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && exe_done && !dec_half && steps_on) |=>
            (dec_valid && dec_half && $stable(dec_pc)));

    p_next_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && exe_done && dec_half && steps_on) |=>
            (mem_rd_en && mem_rd_addr == AW'($past(dec_pc) + AW'(1))));

    p_jump_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && exe_done && op_jmp) |=>
            (mem_rd_en && mem_rd_addr == $past(dec_instr[AW-1:0])));

    p_jge_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && exe_done && op_jge && !acc_sign) |=>
            (mem_rd_en && mem_rd_addr == $past(dec_instr[AW-1:0])));
endmodule

bind pkd_fetch_seq pkd_fetch_seq_chk #(.AW(AW), .IW(IW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .dec_valid   (dec_valid),
    .dec_instr   (dec_instr),
    .dec_pc      (dec_pc),
    .dec_half    (dec_half),
    .exe_done    (exe_done),
    .acc_sign    (acc_sign)
);

// File: tb/pkd_fetch_seq_tb_top.sv
module pkd_fetch_seq_tb_top;
    localparam int AW = 12;
    localparam int IW = 20;
    localparam int NV = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [39:0]   mem_rd_data = '0;
    logic          dec_valid;
    logic [IW-1:0] dec_instr;
    logic [AW-1:0] dec_pc;
    logic          dec_half;
    logic          exe_done = 1'b0;
    logic          acc_sign = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int rd_total = 0;
    bit done_all = 1'b0;

    always #5 clk = ~clk;

    pkd_fetch_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .dec_valid(dec_valid), .dec_instr(dec_instr), .dec_pc(dec_pc), .dec_half(dec_half),
        .exe_done(exe_done), .acc_sign(acc_sign)
    );

    // Memory contents: default word holds {0x06,addr} high and {0x01,addr} low.
    function automatic logic [39:0] mem_word(input logic [11:0] a);
        logic [19:0] lo, hi;
        lo = {8'h01, a};
        hi = {8'h06, a};
        case (a)
            12'h001: lo = {8'h08, 12'h010};
            12'h010: lo = {8'h09, 12'h020};
            12'h020: hi = {8'h0A, 12'h030};
            12'h021: begin lo = {8'h0B, 12'h021}; hi = {8'h0A, 12'h040}; end
            12'h040: lo = {8'h08, 12'hFFF};
            default: ;
        endcase
        return {hi, lo};
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem_word(mem_rd_addr);
        if (rst_n && mem_rd_en) rd_total <= rd_total + 1;
    end

    typedef struct packed {
        logic [11:0] pc;
        logic        half;
        logic [19:0] instr;
        logic [1:0]  reads;
        logic        sign;
        logic [1:0]  stall;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [0:NV-1] = '{
        '{12'h000, 1'b0, {8'h01,12'h000}, 2'd1, 1'b0, 2'd0, 4'd3},  // R1 R3 first word
        '{12'h000, 1'b1, {8'h06,12'h000}, 2'd0, 1'b0, 2'd2, 4'd4},  // R4 high half, no read
        '{12'h001, 1'b0, {8'h08,12'h010}, 2'd1, 1'b1, 2'd0, 4'd5},  // R5 next word
        '{12'h010, 1'b0, {8'h09,12'h020}, 2'd1, 1'b0, 2'd1, 4'd6},  // R6 0x08 target
        '{12'h020, 1'b1, {8'h0A,12'h030}, 2'd1, 1'b1, 2'd0, 4'd6},  // R6 0x09 -> half 1
        '{12'h021, 1'b0, {8'h0B,12'h021}, 2'd1, 1'b0, 2'd0, 4'd7},  // R7 0x0A not taken
        '{12'h021, 1'b1, {8'h0A,12'h040}, 2'd1, 1'b0, 2'd0, 4'd9},  // R9 same-word refetch
        '{12'h040, 1'b0, {8'h08,12'hFFF}, 2'd1, 1'b1, 2'd0, 4'd7},  // R7 0x0A taken
        '{12'hFFF, 1'b0, {8'h01,12'hFFF}, 2'd1, 1'b0, 2'd0, 4'd7},  // R7 0x08 ignores sign
        '{12'hFFF, 1'b1, {8'h06,12'hFFF}, 2'd0, 1'b0, 2'd3, 4'd8},  // R8 long stall
        '{12'h000, 1'b0, {8'h01,12'h000}, 2'd1, 1'b0, 2'd0, 4'd5}   // R5 wrap 4095 -> 0
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_valid(input string req);
        int t = 0;
        while (!dec_valid && t < 50) begin
            @(negedge clk);
            t++;
        end
        chk(dec_valid, req, longint'(dec_valid), 1);
    endtask

    task automatic pulse_done(input logic s);
        acc_sign = s;
        exe_done = 1'b1;
        @(negedge clk);
        exe_done = 1'b0;
        acc_sign = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done_all) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_rd_en == 1'b1 && mem_rd_addr == 12'h000, "R1 read addr", {mem_rd_en, mem_rd_addr}, {1'b1, 12'h000});
        chk(!dec_valid && dec_pc == 12'h000 && !dec_half, "R1 pc/half", {dec_valid, dec_pc, dec_half}, 0);
        rst_n = 1'b1;
        // R8: done while nothing offered is ignored
        exe_done = 1'b1;
        @(negedge clk);
        chk(!dec_valid && !mem_rd_en, "R2 gap", {dec_valid, mem_rd_en}, 0);
        @(negedge clk);
        exe_done = 1'b0;
        snap = 0;
        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[v].req);
            wait_valid(tag);
            chk(dec_pc == VECS[v].pc, tag, dec_pc, VECS[v].pc);
            chk(dec_half == VECS[v].half, tag, dec_half, VECS[v].half);
            chk(dec_instr == VECS[v].instr, tag, dec_instr, VECS[v].instr);
            chk(rd_total - snap == int'(VECS[v].reads), tag, rd_total - snap, VECS[v].reads);
            for (int s = 0; s < int'(VECS[v].stall); s++) begin
                @(negedge clk);
                chk(dec_valid && dec_instr == VECS[v].instr && dec_pc == VECS[v].pc,
                    "R8 hold", dec_instr, VECS[v].instr);
            end
            snap = rd_total;
            pulse_done(VECS[v].sign);
        end
        // R1 reset in mid-run returns to word 0
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(mem_rd_en && mem_rd_addr == 12'h000 && !dec_valid, "R1 mid-run reset",
            {mem_rd_en, mem_rd_addr}, {1'b1, 12'h000});
        rst_n = 1'b1;
        wait_valid("R1");
        chk(dec_pc == 12'h000 && !dec_half && dec_instr == {8'h01, 12'h000}, "R1 refetch word 0",
            dec_instr, {8'h01, 12'h000});
        done_all = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule